// File: doc/BRIEF.md
# Two-Channel Pattern Fill Engine

This block clears or paints regions of memory without processor involvement. It holds two independent fill channels. Each channel has four registers: a start address, an end address, a pattern value and a control word. Software programs the registers and then sets the go bit in the control word. The channel then walks the byte range from the start address up to, but not including, the end address. At each step it emits one pattern element on a byte-enabled memory write port.

Address registers hold the byte address divided by eight. The control word selects the pattern width (16, 24 or 32 bits) and reports completion through a done flag. When a fill finishes, the channel clears its go bit and sets its done bit. It can also pulse a per-channel interrupt.

The two channels share a single write port. When both are active, the lower-numbered channel always wins the port. Reset is asserted asynchronously and released synchronously inside the block.

Top module: `memfill_engine`

## Requirements
- R1: After reset every channel register reads zero, `mem_req` is low and both `irq` bits are low.
- R2: Register index 0 is the start address and index 1 is the end address; both hold the byte address divided by 8. Index 2 is the pattern value. Index 3 is control: bit 0 go, bit 1 done, bit 8 selects 24-bit, bit 9 selects 32-bit. All four registers read back through `rd_data` exactly as written while the channel is idle.
- R3: 16-bit mode is selected when neither bit 8 nor bit 9 is set. Each element carries value[15:0] on `mem_wdata[15:0]` with `mem_be`=0011. It is written at byte address `mem_addr`, low byte first. Addresses step by 2 from start*8 while the address is below end*8.
- R4: 24-bit mode places value[7:0], value[15:8] and value[23:16] on lanes 0..2 with `mem_be`=0111. Addresses step by 3. The last element may reach past end*8.
- R5: 32-bit mode writes the full value with `mem_be`=1111, stepping by 4. This covers (end-start)*8/4 words.
- R6: When bits 8 and 9 are both set, the channel behaves as 24-bit mode.
- R7: On completion the go bit reads 0 and the done bit reads 1.
- R8: On completion `irq[ch]` pulses high for exactly one cycle, but only when the start register is nonzero.
- R9: If end is less than or equal to start, a triggered fill writes no memory and still completes as in R7 and R8.
- R10: While a channel's go bit is set, register writes to that channel have no effect.
- R11: When both channels request the port, channel 0 is served first.
- R12: An element is held unchanged on the port until a cycle with `mem_ready` high accepts it. Only then does the channel advance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_ch | input | 1 | Channel selected for the write |
| reg_idx | input | 2 | Register index for the write |
| reg_wdata | input | 32 | Register write data |
| rd_ch | input | 1 | Channel selected for reading |
| rd_idx | input | 2 | Register index for reading |
| rd_data | output | 32 | Read data (combinational) |
| mem_req | output | 1 | Write element valid |
| mem_addr | output | 29 | Byte address of lane 0 |
| mem_wdata | output | 32 | Element data, lane 0 in bits 7:0 |
| mem_be | output | 4 | Byte lane enables |
| mem_ready | input | 1 | Memory accepts the element this cycle |
| irq | output | 2 | Per-channel completion pulse |

## Verification
The 24-bit case is chosen so the range is not a multiple of three. A design that stopped at the end address rather than at the first step beyond it would leave the final two bytes unwritten. Empty ranges and a zero start address are each driven separately. A design that skipped completion on an empty range would hang with go set, and one that ignored the zero-start rule would raise a spurious interrupt.

Writes issued mid-fill under a stalled port are read back afterwards. Any design that latched them would show altered registers or corrupted memory. An arbitration scenario arms channel 1 before channel 0. A design with the wrong priority would emit a channel-1 address first.

// File: rtl/memfill_pkg.sv
package memfill_pkg;

  typedef enum logic [1:0] {
    PAT16 = 2'd0,
    PAT24 = 2'd1,
    PAT32 = 2'd2
  } pat_e;

  localparam logic [1:0] IDX_START = 2'd0;
  localparam logic [1:0] IDX_END   = 2'd1;
  localparam logic [1:0] IDX_VALUE = 2'd2;
  localparam logic [1:0] IDX_CTRL  = 2'd3;

  localparam int CTL_GO    = 0;
  localparam int CTL_DONE  = 1;
  localparam int CTL_SEL24 = 8;
  localparam int CTL_SEL32 = 9;

  function automatic logic [2:0] pat_step(pat_e p);
    case (p)
      PAT24:   return 3'd3;
      PAT32:   return 3'd4;
      default: return 3'd2;
    endcase
  endfunction

  function automatic logic [3:0] pat_lanes(pat_e p);
    case (p)
      PAT24:   return 4'b0111;
      PAT32:   return 4'b1111;
      default: return 4'b0011;
    endcase
  endfunction

endpackage

// File: rtl/memfill_chan.sv
module memfill_chan
  import memfill_pkg::*;
#(
  parameter int RAW_W = 26
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en_i,
  input  logic [1:0]           wr_idx_i,
  input  logic [31:0]          wr_data_i,
  input  logic [1:0]           rd_idx_i,
  output logic [31:0]          rd_data_o,
  output logic                 req_o,
  output logic [RAW_W+2:0]     addr_o,
  output logic [31:0]          wdata_o,
  output logic [3:0]           be_o,
  input  logic                 acc_i,
  output logic                 irq_o
);
  localparam int PA_W  = RAW_W + 3;
  localparam int PTR_W = PA_W + 1;

  logic [RAW_W-1:0] start_q, start_d, end_q, end_d;
  logic [31:0]      val_q, val_d;
  logic             go_q, go_d, fin_q, fin_d;
  logic             s24_q, s24_d, s32_q, s32_d;
  logic             irq_q, irq_d;
  logic [PTR_W-1:0] ptr_q, ptr_d;
  logic             cfg_en, run_en;

  pat_e             pat;
  logic [PTR_W-1:0] end_ptr, step_ext, ptr_nxt;
  logic             more, last;

  always_comb begin
    pat      = s24_q ? PAT24 : (s32_q ? PAT32 : PAT16);
    end_ptr  = PTR_W'({end_q, 3'b000});
    step_ext = PTR_W'(pat_step(pat));
    ptr_nxt  = ptr_q + step_ext;
    more     = ptr_q < end_ptr;
    last     = go_q && (!more || (acc_i && (ptr_nxt >= end_ptr)));
  end

  assign req_o  = go_q && more;
  assign addr_o = ptr_q[PA_W-1:0];
  assign be_o   = pat_lanes(pat);
  assign irq_o  = irq_q;

  always_comb begin
    case (pat)
      PAT24:   wdata_o = {8'h00, val_q[23:16], val_q[15:8], val_q[7:0]};
      PAT32:   wdata_o = val_q;
      default: wdata_o = {16'h0000, val_q[15:0]};
    endcase
  end

  always_comb begin
    case (rd_idx_i)
      IDX_START: rd_data_o = 32'(start_q);
      IDX_END:   rd_data_o = 32'(end_q);
      IDX_VALUE: rd_data_o = val_q;
      default: begin
        rd_data_o            = '0;
        rd_data_o[CTL_GO]    = go_q;
        rd_data_o[CTL_DONE]  = fin_q;
        rd_data_o[CTL_SEL24] = s24_q;
        rd_data_o[CTL_SEL32] = s32_q;
      end
    endcase
  end

  // next-state
  always_comb begin
    cfg_en  = wr_en_i && !go_q;
    run_en  = go_q;
    start_d = start_q;
    end_d   = end_q;
    val_d   = val_q;
    go_d    = go_q;
    fin_d   = fin_q;
    s24_d   = s24_q;
    s32_d   = s32_q;
    ptr_d   = ptr_q;
    irq_d   = 1'b0;
    if (cfg_en) begin
      case (wr_idx_i)
        IDX_START: start_d = wr_data_i[RAW_W-1:0];
        IDX_END:   end_d   = wr_data_i[RAW_W-1:0];
        IDX_VALUE: val_d   = wr_data_i;
        default: begin
          go_d  = wr_data_i[CTL_GO];
          fin_d = wr_data_i[CTL_DONE];
          s24_d = wr_data_i[CTL_SEL24];
          s32_d = wr_data_i[CTL_SEL32];
          ptr_d = PTR_W'({start_q, 3'b000});
        end
      endcase
    end else if (run_en) begin
      if (acc_i) ptr_d = ptr_nxt;
      if (last) begin
        go_d  = 1'b0;
        fin_d = 1'b1;
        irq_d = (start_q != '0);
      end
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q <= '0;
      end_q   <= '0;
      val_q   <= '0;
      go_q    <= 1'b0;
      fin_q   <= 1'b0;
      s24_q   <= 1'b0;
      s32_q   <= 1'b0;
      ptr_q   <= '0;
      irq_q   <= 1'b0;
    end else begin
      irq_q <= irq_d;
      if (cfg_en || run_en) begin
        start_q <= start_d;
        end_q   <= end_d;
        val_q   <= val_d;
        go_q    <= go_d;
        fin_q   <= fin_d;
        s24_q   <= s24_d;
        s32_q   <= s32_d;
        ptr_q   <= ptr_d;
      end
    end
  end

  p_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (req_o && !acc_i) |=> (req_o && $stable(ptr_q) && $stable(wdata_o)));

  p_advance_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_i && go_q && !last) |=> ((ptr_q - $past(ptr_q)) == PTR_W'(pat_step(pat))));

  p_done_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(go_q) |-> fin_q);

  p_irq_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> ((start_q != '0) && fin_q && !go_q));

  p_freeze_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $past(go_q) |-> ($stable(start_q) && $stable(end_q) && $stable(val_q)));

endmodule

// File: rtl/memfill_arb.sv
module memfill_arb #(
  parameter int NCH = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] req_i,
  output logic [NCH-1:0] gnt_o
);
  logic [NCH:0] taken;

  assign taken[0] = 1'b0;
  for (genvar i = 0; i < NCH; i++) begin : g_prio
    assign gnt_o[i]   = req_i[i] && !taken[i];
    assign taken[i+1] = taken[i] || req_i[i];
  end

  p_onehot_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt_o));

  p_low_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i[0]) |-> (gnt_o[0]));

endmodule

// File: rtl/memfill_engine.sv
module memfill_engine
  import memfill_pkg::*;
#(
  parameter int NCH   = 2,
  parameter int RAW_W = 26,
  localparam int CH_W = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int PA_W = RAW_W + 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            reg_we,
  input  logic [CH_W-1:0] reg_ch,
  input  logic [1:0]      reg_idx,
  input  logic [31:0]     reg_wdata,
  input  logic [CH_W-1:0] rd_ch,
  input  logic [1:0]      rd_idx,
  output logic [31:0]     rd_data,
  output logic            mem_req,
  output logic [PA_W-1:0] mem_addr,
  output logic [31:0]     mem_wdata,
  output logic [3:0]      mem_be,
  input  logic            mem_ready,
  output logic [NCH-1:0]  irq
);
  logic [1:0] rst_pipe;
  logic       rst_s_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_s_n = rst_pipe[1];

  logic [NCH-1:0]       req, gnt;
  logic [31:0]          rd_bus [NCH];
  logic [PA_W-1:0]      addr_bus [NCH];
  logic [31:0]          data_bus [NCH];
  logic [3:0]           be_bus [NCH];

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    memfill_chan #(.RAW_W(RAW_W)) u_chan (
      .clk       (clk),
      .rst_n     (rst_s_n),
      .wr_en_i   (reg_we && (reg_ch == CH_W'(i))),
      .wr_idx_i  (reg_idx),
      .wr_data_i (reg_wdata),
      .rd_idx_i  (rd_idx),
      .rd_data_o (rd_bus[i]),
      .req_o     (req[i]),
      .addr_o    (addr_bus[i]),
      .wdata_o   (data_bus[i]),
      .be_o      (be_bus[i]),
      .acc_i     (gnt[i] && mem_ready),
      .irq_o     (irq[i])
    );
  end

  memfill_arb #(.NCH(NCH)) u_arb (
    .clk   (clk),
    .rst_n (rst_s_n),
    .req_i (req),
    .gnt_o (gnt)
  );

  always_comb begin
    mem_addr  = '0;
    mem_wdata = '0;
    mem_be    = '0;
    rd_data   = '0;
    for (int i = 0; i < NCH; i++) begin
      if (gnt[i]) begin
        mem_addr  = mem_addr  | addr_bus[i];
        mem_wdata = mem_wdata | data_bus[i];
        mem_be    = mem_be    | be_bus[i];
      end
      if (rd_ch == CH_W'(i)) rd_data = rd_bus[i];
    end
  end
  assign mem_req = |gnt;

  p_be_shape_r3: assert property (@(posedge clk) disable iff (!rst_s_n)
    mem_req |-> (mem_be[1:0] == 2'b11 && $countones(mem_be) >= 2));

endmodule

// File: tb/memfill_engine_test.sv
module memfill_engine_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_we;
  logic [0:0]  reg_ch;
  logic [1:0]  reg_idx;
  logic [31:0] reg_wdata;
  logic [0:0]  rd_ch;
  logic [1:0]  rd_idx;
  logic [31:0] rd_data;
  logic        mem_req;
  logic [28:0] mem_addr;
  logic [31:0] mem_wdata;
  logic [3:0]  mem_be;
  logic        mem_ready;
  logic [1:0]  irq;

  always #10 clk = ~clk;

  memfill_engine uut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_ch(reg_ch), .reg_idx(reg_idx),
    .reg_wdata(reg_wdata), .rd_ch(rd_ch), .rd_idx(rd_idx), .rd_data(rd_data),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_be(mem_be),
    .mem_ready(mem_ready), .irq(irq)
  );

  int n_tests = 0;
  int n_fail  = 0;

  logic [7:0] mem [0:1023];
  logic [7:0] exp_mem [0:1023];
  int         irq_cnt0 = 0, irq_cnt1 = 0;
  logic       first_seen;
  logic [28:0] first_addr;
  int         stall_mode = 0;
  logic [7:0] lfsr = 8'h5A;

  always @(posedge clk) begin
    if (mem_req && mem_ready) begin
      for (int k = 0; k < 4; k++)
        if (mem_be[k]) mem[(int'(mem_addr) + k) % 1024] <= mem_wdata[8*k +: 8];
      if (!first_seen) begin
        first_seen <= 1'b1;
        first_addr <= mem_addr;
      end
    end
    if (irq[0]) irq_cnt0++;
    if (irq[1]) irq_cnt1++;
  end

  always @(negedge clk) begin
    lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    case (stall_mode)
      0: mem_ready <= 1'b1;
      1: mem_ready <= lfsr[0] | lfsr[2];
      default: mem_ready <= 1'b0;
    endcase
  end

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic reg_write(input int ch, input logic [1:0] idx, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_ch = 1'(ch); reg_idx = idx; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic reg_read(input int ch, input logic [1:0] idx, output logic [31:0] d);
    rd_ch = 1'(ch); rd_idx = idx;
    #1 d = rd_data;
  endtask

  task automatic clear_mem();
    for (int i = 0; i < 1024; i++) begin
      mem[i] = 8'hEE;
      exp_mem[i] = 8'hEE;
    end
  endtask

  // mode: 0=16, 1=24, 2=32
  task automatic model_fill(input int s, input int e, input logic [31:0] v, input int mode);
    int p, stp, nb;
    stp = (mode == 1) ? 3 : (mode == 2) ? 4 : 2;
    nb = stp;
    p = s * 8;
    while (p < e * 8) begin
      for (int k = 0; k < nb; k++) exp_mem[(p + k) % 1024] = v[8*k +: 8];
      p += stp;
    end
  endtask

  task automatic compare_mem(input string tag);
    int bad = -1;
    for (int i = 0; i < 1024; i++)
      if (bad < 0 && mem[i] !== exp_mem[i]) bad = i;
    if (bad < 0) check(1'b1, tag, 0, 0);
    else check(1'b0, $sformatf("%s byte@%0d", tag, bad), mem[bad], exp_mem[bad]);
  endtask

  task automatic wait_idle(input int ch, input string tag);
    logic [31:0] c;
    int n = 0;
    reg_read(ch, 2'd3, c);
    while (c[0] && n < 3000) begin
      @(negedge clk);
      reg_read(ch, 2'd3, c);
      n++;
    end
    check(!c[0], {tag, " go clears"}, c, 0);
    repeat (2) @(negedge clk);
  endtask

  task automatic run_fill(input int ch, input int s, input int e, input logic [31:0] v,
                          input logic [31:0] ctrl, input int mode, input string tag,
                          input int exp_irq);
    logic [31:0] c;
    int i0, i1, di;
    clear_mem();
    model_fill(s, e, v, mode);
    i0 = irq_cnt0; i1 = irq_cnt1;
    reg_write(ch, 2'd0, s);
    reg_write(ch, 2'd1, e);
    reg_write(ch, 2'd2, v);
    reg_write(ch, 2'd3, ctrl);
    wait_idle(ch, tag);
    compare_mem({tag, " memory"});
    reg_read(ch, 2'd3, c);
    check(c == ((ctrl & 32'h300) | 32'h2), {tag, " R7 status"}, c, (ctrl & 32'h300) | 32'h2);
    di = (ch == 0) ? irq_cnt0 - i0 : irq_cnt1 - i1;
    check(di == exp_irq, {tag, " R8 irq count"}, di, exp_irq);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    for (int ch = 0; ch < 2; ch++)
      for (int idx = 0; idx < 4; idx++) begin
        reg_read(ch, 2'(idx), d);
        check(d == 0, "R1 reg zero", d, 0);
      end
    check(mem_req == 1'b0 && irq == 2'b00, "R1 outputs idle", {mem_req, irq}, 0);
  endtask

  task automatic t_regmap();
    logic [31:0] d;
    reg_write(1, 2'd0, 32'h0012345);
    reg_write(1, 2'd1, 32'h0000077);
    reg_write(1, 2'd2, 32'hDEADBEEF);
    reg_write(1, 2'd3, 32'h00000302);
    reg_read(1, 2'd0, d); check(d == 32'h12345, "R2 start readback", d, 32'h12345);
    reg_read(1, 2'd1, d); check(d == 32'h77, "R2 end readback", d, 32'h77);
    reg_read(1, 2'd2, d); check(d == 32'hDEADBEEF, "R2 value readback", d, 32'hDEADBEEF);
    reg_read(1, 2'd3, d); check(d == 32'h302, "R2 ctrl readback", d, 32'h302);
    check(mem_req == 1'b0, "R2 no fill without go", mem_req, 0);
    reg_write(1, 2'd3, 32'h0);
  endtask

  task automatic t_busy_ignored();
    logic [31:0] d;
    clear_mem();
    model_fill(2, 4, 32'h0000A55A, 0);
    stall_mode = 2;
    reg_write(0, 2'd0, 2);
    reg_write(0, 2'd1, 4);
    reg_write(0, 2'd2, 32'h0000A55A);
    reg_write(0, 2'd3, 32'h1);
    reg_write(0, 2'd0, 10);
    reg_write(0, 2'd2, 32'h11111111);
    reg_write(0, 2'd3, 32'h300);
    reg_read(0, 2'd0, d); check(d == 2, "R10 start kept", d, 2);
    reg_read(0, 2'd2, d); check(d == 32'hA55A, "R10 value kept", d, 32'hA55A);
    reg_read(0, 2'd3, d); check(d == 32'h1, "R10 ctrl kept", d, 1);
    check(mem_req && mem_addr == 29'd16, "R12 held while stalled", mem_addr, 16);
    stall_mode = 1;
    wait_idle(0, "R10");
    compare_mem("R10 R12 memory under stalls");
    stall_mode = 0;
  endtask

  task automatic t_priority();
    clear_mem();
    model_fill(20, 22, 32'hCAFEF00D, 2);
    model_fill(10, 12, 32'h00003C3C, 0);
    stall_mode = 2;
    reg_write(1, 2'd0, 20); reg_write(1, 2'd1, 22);
    reg_write(1, 2'd2, 32'hCAFEF00D); reg_write(1, 2'd3, 32'h201);
    reg_write(0, 2'd0, 10); reg_write(0, 2'd1, 12);
    reg_write(0, 2'd2, 32'h00003C3C); reg_write(0, 2'd3, 32'h1);
    @(negedge clk);
    first_seen = 1'b0;
    stall_mode = 0;
    wait_idle(0, "R11 ch0");
    wait_idle(1, "R11 ch1");
    check(first_addr == 29'd80, "R11 ch0 served first", first_addr, 80);
    compare_mem("R11 both fills");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; reg_we = 1'b0; reg_ch = '0; reg_idx = '0; reg_wdata = '0;
    rd_ch = '0; rd_idx = '0; mem_ready = 1'b1; first_seen = 1'b1; first_addr = '0;
    clear_mem();
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_regmap();
    run_fill(0, 2, 4, 32'hABCD1234, 32'h001, 0, "R3 16-bit", 1);
    run_fill(1, 1, 3, 32'h00C0FFEE, 32'h101, 1, "R4 24-bit overrun", 1);
    run_fill(0, 4, 6, 32'h89ABCDEF, 32'h201, 2, "R5 32-bit", 1);
    run_fill(1, 3, 5, 32'h00445566, 32'h301, 1, "R6 both selects", 1);
    run_fill(0, 6, 6, 32'h12345678, 32'h001, 0, "R9 empty equal", 1);
    run_fill(1, 9, 4, 32'h12345678, 32'h201, 2, "R9 empty reversed", 1);
    run_fill(0, 0, 2, 32'h00007E81, 32'h001, 0, "R8 zero start", 0);
    stall_mode = 1;
    run_fill(1, 8, 11, 32'h00A1B2C3, 32'h101, 1, "R12 24-bit stalled", 1);
    stall_mode = 0;
    t_busy_ignored();
    t_priority();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule